// File: doc/BRIEF.md
# Embedded-Clock 10-Bit Word Serializer

This block turns a 10-bit parallel word into a 12-bit serial frame. Each frame carries the payload together with two framing bits, and those framing bits embed the clock. A rising transition sits at every frame boundary, so a receiver can recover word timing from the line alone.

The parallel word is sampled on a word clock, which arrives as a level and is sampled in the fast domain. An input picks whether the rising or the falling edge of that clock captures the data. A bit-clock enable from outside pulses twelve times per word period, and each pulse moves one bit onto the line. A sync request makes the block send a fixed clock-like pattern in place of user data for a minimum number of frames, so a receiver can lock quickly. A power-down input halts transmission. An output-disable input drops the output-enable flag, which models a high-impedance driver, while framing keeps running underneath.

Top module: `emb_clk_serializer`

## Requirements
- R1: A data frame is 12 bits sent in this order: a start bit of 1, then payload bits 0 through 9 (least significant first), then a stop bit of 0.
- R2: `ser_out` moves one frame bit per cycle with `bit_en` high and holds its value in cycles where `bit_en` is low.
- R3: With `edge_sel` = 0, `data_in` is captured in the cycle where `word_clk` is first seen high after being low.
- R4: With `edge_sel` = 1, `data_in` is captured on the high-to-low transition of `word_clk`, and the rising transition captures nothing.
- R5: When no new capture has taken place, the next frame repeats the last captured word.
- R6: A SYNC frame is 12 bits: six ones first, then six zeros.
- R7: A change of `sync_req` takes effect only when a new frame is loaded. A frame that is already in flight is completed unchanged.
- R8: Once a frame boundary sees `sync_req` high, SYNC frames are sent for exactly 1024 consecutive frames (parameter `SYNC_FRAMES`), counted from the last boundary at which the request was seen. Data frames resume after that.
- R9: While `pwr_dn` is high, `ser_out` and `ser_oe` are 0 from the next cycle on, and the frame in flight is dropped.
- R10: After `pwr_dn` falls, `ser_out` stays 0 until the next `bit_en` pulse. That pulse starts a fresh frame with its start bit.
- R11: While `out_dis` is high, `ser_oe` is 0 from the next cycle on. The serial bit sequence on `ser_out` goes on without a break.
- R12: During reset, `ser_out` and `ser_oe` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; all state is registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_clk | input | 1 | Word clock, sampled as a level |
| edge_sel | input | 1 | 0: capture on rising word-clock edge; 1: capture on falling edge |
| data_in | input | 10 | Parallel payload word |
| bit_en | input | 1 | Bit-rate enable, twelve pulses per word |
| sync_req | input | 1 | Request SYNC frames in place of data |
| pwr_dn | input | 1 | Power-down: halts transmission |
| out_dis | input | 1 | Output disable: drops output enable and keeps framing running |
| ser_out | output | 1 | Serial line bit |
| ser_oe | output | 1 | Output enable; 0 models a high-impedance driver |

## Verification
The bench puts a sync request in the middle of a data frame. A design that switched patterns at once would cut that frame short. It then counts the SYNC frames that follow: one fewer or one more frame shows up as a wrong count before data resumes. The bench captures on the opposite edge with different data on each edge, so a wrong edge choice sends the wrong word. It stalls `bit_en` in mid-frame, disables the output in mid-frame, and powers down in mid-frame. These expose a design that slips a bit, a design that resets framing on disable, and a design that resumes a stale frame or leaves the line high after power-down.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_e;
endpackage

// File: rtl/ecs_word_capture.sv
module ecs_word_capture
    import ecs_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_clk,
    input  logic              edge_sel,
    input  logic [WORD_W-1:0] data_in,
    output logic [WORD_W-1:0] word_q
);
    typedef struct packed {
        logic              wclk;
        logic [WORD_W-1:0] word;
    } cap_t;

    cap_t  st_d, st_q;
    edge_e mode;
    logic  seen_rise, seen_fall, take;

    always_comb begin
        mode      = edge_e'(edge_sel);
        seen_rise = word_clk && !st_q.wclk;
        seen_fall = !word_clk && st_q.wclk;
        take      = (mode == EDGE_RISE) ? seen_rise : seen_fall;
        st_d      = st_q;
        st_d.wclk = word_clk;
        if (take) begin
            st_d.word = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q = st_q.word;

    AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (word_q == $past(data_in))); // R3

    AST_NO_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(word_q)); // R5
endmodule

// File: rtl/ecs_frame_mux.sv
module ecs_frame_mux #(
    parameter int WORD_W = 10,
    localparam int FRAME_W = WORD_W + 2
) (
    input  logic [WORD_W-1:0]  word,
    input  logic               sync_sel,
    output logic [FRAME_W-1:0] frame
);
    logic [FRAME_W-1:0] sync_pat;

    for (genvar i = 0; i < FRAME_W; i++) begin : g_sync
        assign sync_pat[i] = (i < FRAME_W / 2);
    end

    always_comb begin
        if (sync_sel) begin
            frame = sync_pat;
        end else begin
            frame = {1'b0, word, 1'b1};
        end
    end
endmodule

// File: rtl/ecs_sync_ctrl.sv
module ecs_sync_ctrl #(
    parameter int SYNC_FRAMES = 1024,
    localparam int SYNC_W = $clog2(SYNC_FRAMES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sync_req,
    input  logic pwr_dn,
    output logic sync_sel
);
    logic [SYNC_W-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (pwr_dn) begin
            left_d = '0;
        end else if (load) begin
            if (sync_req) begin
                left_d = SYNC_W'(SYNC_FRAMES - 1);
            end else if (left_q != '0) begin
                left_d = left_q - SYNC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign sync_sel = sync_req || (left_q != '0);

    AST_SYNC_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !pwr_dn) |=> $stable(left_q)); // R7

    AST_SYNC_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !sync_req && !pwr_dn && left_q == '0) |=> (left_q == '0)); // R8
endmodule

// File: rtl/emb_clk_serializer.sv
module emb_clk_serializer #(
    parameter int WORD_W      = 10,
    parameter int SYNC_FRAMES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_clk,
    input  logic              edge_sel,
    input  logic [WORD_W-1:0] data_in,
    input  logic              bit_en,
    input  logic              sync_req,
    input  logic              pwr_dn,
    input  logic              out_dis,
    output logic              ser_out,
    output logic              ser_oe
);
    localparam int FRAME_W = WORD_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic               out;
        logic               oe;
    } ser_t;

    ser_t               st_d, st_q;
    logic [WORD_W-1:0]  word;
    logic [FRAME_W-1:0] frame;
    logic               sync_sel, load;

    ecs_word_capture #(.WORD_W(WORD_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_clk (word_clk),
        .edge_sel (edge_sel),
        .data_in  (data_in),
        .word_q   (word)
    );

    ecs_sync_ctrl #(.SYNC_FRAMES(SYNC_FRAMES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .sync_req (sync_req),
        .pwr_dn   (pwr_dn),
        .sync_sel (sync_sel)
    );

    ecs_frame_mux #(.WORD_W(WORD_W)) u_mux (
        .word     (word),
        .sync_sel (sync_sel),
        .frame    (frame)
    );

    assign load = bit_en && !pwr_dn && (st_q.cnt == '0);

    always_comb begin
        st_d    = st_q;
        st_d.oe = !out_dis && !pwr_dn;
        if (pwr_dn) begin
            st_d.sh  = '0;
            st_d.cnt = '0;
            st_d.out = 1'b0;
        end else if (bit_en) begin
            if (st_q.cnt == '0) begin
                st_d.out = frame[0];
                st_d.sh  = frame >> 1;
                st_d.cnt = CNT_W'(1);
            end else begin
                st_d.out = st_q.sh[0];
                st_d.sh  = st_q.sh >> 1;
                st_d.cnt = (st_q.cnt == LAST_BIT) ? '0 : st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = st_q.out;
    assign ser_oe  = st_q.oe;

    AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !sync_sel) |=> ser_out); // R1

    AST_STOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !pwr_dn && st_q.cnt == LAST_BIT) |=> !ser_out); // R1

    AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !pwr_dn) |=> $stable(ser_out)); // R2

    AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!ser_out && !ser_oe)); // R9

    AST_DISABLE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |=> !ser_oe); // R11
endmodule

// File: tb/emb_clk_serializer_bench.sv
module emb_clk_serializer_bench;
    localparam int W  = 10;
    localparam int FW = 12;
    localparam int NS = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          word_clk = 1'b0;
    logic          edge_sel = 1'b0;
    logic [W-1:0]  data_in = '0;
    logic          bit_en = 1'b0;
    logic          sync_req = 1'b0;
    logic          pwr_dn = 1'b0;
    logic          out_dis = 1'b0;
    logic          ser_out, ser_oe;

    int checks = 0;
    int fails  = 0;

    emb_clk_serializer u_emb_clk_serializer (
        .clk(clk), .rst_n(rst_n), .word_clk(word_clk), .edge_sel(edge_sel),
        .data_in(data_in), .bit_en(bit_en), .sync_req(sync_req),
        .pwr_dn(pwr_dn), .out_dis(out_dis), .ser_out(ser_out), .ser_oe(ser_oe)
    );

    always #5 clk = ~clk;

    function automatic logic [FW-1:0] data_frame(logic [W-1:0] w);
        return {1'b0, w, 1'b1};
    endfunction

    localparam logic [FW-1:0] SYNC_F = 12'b0000_0011_1111;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic shift_bits(input int n, inout logic [FW-1:0] acc, inout int pos);
        for (int i = 0; i < n; i++) begin
            bit_en = 1'b1;
            tick();
            acc[pos] = ser_out;
            pos++;
        end
        bit_en = 1'b0;
    endtask

    task automatic grab_frame(output logic [FW-1:0] f);
        int p = 0;
        logic [FW-1:0] a = '0;
        shift_bits(FW, a, p);
        f = a;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        check(ser_out == 1'b0 && ser_oe == 1'b0, "R12", {ser_out, ser_oe}, 0);
        rst_n = 1'b1;
        tick();
        check(ser_oe == 1'b1, "R12 oe after reset", ser_oe, 1);
    endtask

    task automatic t_rise_capture();
        logic [FW-1:0] f;
        edge_sel = 1'b0;
        data_in = 10'h2A5; word_clk = 1'b1; tick();
        data_in = 10'h0F0; word_clk = 1'b0; tick();
        grab_frame(f);
        check(f == data_frame(10'h2A5), "R3 R1 rising capture frame", f, data_frame(10'h2A5));
        grab_frame(f);
        check(f == data_frame(10'h2A5), "R5 repeated word", f, data_frame(10'h2A5));
    endtask

    task automatic t_fall_capture();
        logic [FW-1:0] f;
        edge_sel = 1'b1;
        data_in = 10'h3C1; word_clk = 1'b1; tick();
        data_in = 10'h155; word_clk = 1'b0; tick();
        data_in = 10'h000; tick();
        grab_frame(f);
        check(f == data_frame(10'h155), "R4 falling capture frame", f, data_frame(10'h155));
        data_in = 10'h111; word_clk = 1'b1; tick();
        grab_frame(f);
        check(f == data_frame(10'h155), "R4 rising edge ignored", f, data_frame(10'h155));
        word_clk = 1'b0; data_in = 10'h201; tick();
        edge_sel = 1'b0;
    endtask

    task automatic t_stall();
        logic [FW-1:0] a = '0;
        int p = 0;
        logic held;
        int bad = 0;
        shift_bits(5, a, p);
        held = ser_out;
        for (int i = 0; i < 4; i++) begin
            tick();
            if (ser_out != held) bad++;
        end
        check(bad == 0, "R2 hold without bit_en", bad, 0);
        shift_bits(7, a, p);
        check(a == data_frame(10'h201), "R2 frame across stall", a, data_frame(10'h201));
    endtask

    task automatic t_sync();
        logic [FW-1:0] a = '0;
        logic [FW-1:0] f;
        int p = 0;
        int bad = 0;
        shift_bits(6, a, p);
        sync_req = 1'b1;
        shift_bits(6, a, p);
        check(a == data_frame(10'h201), "R7 frame in flight kept", a, data_frame(10'h201));
        a = '0; p = 0;
        shift_bits(1, a, p);
        sync_req = 1'b0;
        shift_bits(11, a, p);
        check(a == SYNC_F, "R6 sync pattern", a, SYNC_F);
        for (int k = 1; k < NS; k++) begin
            grab_frame(f);
            if (f != SYNC_F) bad++;
        end
        check(bad == 0, "R8 sync frames count", bad, 0);
        grab_frame(f);
        check(f == data_frame(10'h201), "R8 data resumes after sync", f, data_frame(10'h201));
    endtask

    task automatic t_out_dis();
        logic [FW-1:0] a = '0;
        int p = 0;
        shift_bits(4, a, p);
        out_dis = 1'b1;
        shift_bits(8, a, p);
        check(ser_oe == 1'b0, "R11 oe low", ser_oe, 0);
        check(a == data_frame(10'h201), "R11 sequence continues", a, data_frame(10'h201));
        out_dis = 1'b0;
        tick();
        check(ser_oe == 1'b1, "R11 oe returns", ser_oe, 1);
    endtask

    task automatic t_power_down();
        logic [FW-1:0] a = '0;
        logic [FW-1:0] f;
        int p = 0;
        int bad = 0;
        shift_bits(5, a, p);
        pwr_dn = 1'b1;
        bit_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (ser_out !== 1'b0 || ser_oe !== 1'b0) bad++;
        end
        check(bad == 0, "R9 idle in power-down", bad, 0);
        bit_en = 1'b0;
        pwr_dn = 1'b0;
        bad = 0;
        for (int i = 0; i < 3; i++) begin
            tick();
            if (ser_out !== 1'b0) bad++;
        end
        check(bad == 0, "R10 low until boundary", bad, 0);
        grab_frame(f);
        check(f == data_frame(10'h201), "R10 fresh frame after power-down", f, data_frame(10'h201));
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_rise_capture();
        t_fall_capture();
        t_stall();
        t_sync();
        t_out_dis();
        t_power_down();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule